// File: doc/BRIEF.md
# Scan List Sequencer

This block walks through a scan list held in a small on-chip list memory. Each list entry holds a sample count and a scan-control code. Once started, the sequencer drives the code of the current entry onto the scan-control lines. Each enabled external trigger pulse decrements the sample count. When the count runs out, the sequencer pauses reading for one cycle to advance to the next entry, then loads that entry. At the end of the list it either stops or wraps back to the first entry, depending on a mode bit.

Software programs the list through a parallel append port. It controls the sequencer through an 8-bit write-only control register that is shifted in serially. Data is sampled on the serial clock's rising edges, most significant bit first. Only bits sent while the slot-select input equals 13 are accepted. The control bits are levels: an active-low bit such as load, rewind or reset acts on every clock for as long as it reads 0.

Top module: `scan_seq`

## Requirements
- R1: The control register shifts `mosi` in on each rising edge of `sclk`, MSB first, while `slotSel` equals 13. When `slotSel` leaves 13 after exactly 8 shifted bits, the byte replaces the control register. A burst of 7 or 9 bits, or bits sent while `slotSel` is some other value, leaves the register unchanged.
- R2: Control register bit positions are: 6 rewind (active low), 5 read enable, 4 one-pass mode, 3 sequencer reset (active low), 2 load (active low), 1 scan-line enable, 0 trigger enable. Bit 7 has no function.
- R3: While `wrEn` is high, each clock appends `wrData` to the list. In `wrData`, bits [15:8] are the sample count and bits [7:0] are the scan-control code. The list holds 32 entries. `fifoFull` is high when 32 entries are stored, and writes made while full are dropped. `fifoEmpty` is high when no entry is stored, and `fifoFull` and `fifoEmpty` are never high together.
- R4: While the load bit is 0 and the list is not empty, `sampleCnt` and the current code are loaded from the entry at the read position, and the sequencer runs with `done` low.
- R5: While running with the trigger-enable bit at 1, each rising edge of `trig` decrements `sampleCnt` by one. With the bit at 0, trigger pulses change nothing.
- R6: A trigger that takes the count to zero is followed by one advance cycle in which reading pauses. On the next cycle the following entry's count and code are loaded.
- R7: While the read-enable bit is 0, the sequencer holds at the entry boundary and does not advance. Setting the bit to 1 lets it advance.
- R8: With the one-pass bit at 1, finishing the last entry raises `done`, drives `scanCon` to all ones, and causes later triggers to be ignored.
- R9: With the one-pass bit at 0, finishing the last entry loads the first entry again, and `done` stays low.
- R10: While the rewind bit is 0, the read position returns to the first entry and the stored entries are kept.
- R11: While the sequencer reset bit is 0, the list is emptied, `sampleCnt` goes to 0, `done` goes low and the code returns to all ones.
- R12: While the scan-line enable bit is 0, `scanCon` is all ones.
- R13: After `rstN` is asserted, the control register holds 0x7C. At that point `scanCon` is 0xFF, `sampleCnt` is 0, `done` is 0, `fifoEmpty` is 1 and `fifoFull` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock for control writes, sampled by clk |
| mosi | input | 1 | Serial data for control writes |
| slotSel | input | 4 | Slot select; 13 addresses this block |
| trig | input | 1 | External trigger, rising edge counts |
| wrEn | input | 1 | List append strobe |
| wrData | input | 16 | List entry: [15:8] count, [7:0] code |
| fifoFull | output | 1 | List holds 32 entries |
| fifoEmpty | output | 1 | List holds no entries |
| scanCon | output | 8 | Scan-control lines, all ones when idle or disabled |
| sampleCnt | output | 8 | Remaining samples of the current entry |
| done | output | 1 | One-pass list finished |

## Verification
The bench targets entry boundaries: a 1-count entry, the advance cycle, the one-pass stop at the last entry, and the wrap back to the first entry. A design that skipped the pause or the reload would show the wrong code or count after a trigger. It also stalls the sequencer with reads disabled at a zero count and checks that it resumes. Truncated 7-bit bursts, 9-bit bursts and writes to another slot must leave the register alone; a design that latched any of them would stop counting triggers. Rewind after a finished pass must reload the first entry's stored values, and the reset bit must empty the list.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  localparam int CTRL_W = 8;
  localparam int B_CLKEN = 0;
  localparam int B_SCANEN = 1;
  localparam int B_LOADN = 2;
  localparam int B_RESETN = 3;
  localparam int B_ONEPASS = 4;
  localparam int B_READEN = 5;
  localparam int B_REWINDN = 6;
  localparam logic [CTRL_W-1:0] CTRL_INIT = 8'h7C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_ADV,
    ST_LOAD,
    ST_DONE
  } seqState_e;

  typedef struct packed {
    logic clearAll;
    logic rewind;
    logic loadEntry;
    logic decCnt;
    logic stepPtr;
    logic wrapPtr;
    logic blankCode;
  } seqStrobe_t;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int SLOT_ADDR = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic [SEL_W-1:0]  slotSel,
  input  logic              trig,
  input  logic              listEmpty,
  input  logic              cntLast,
  input  logic              atLast,
  output seqStrobe_t        stb,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic              done
);

  localparam int BCNT_W = $clog2(CTRL_W + 2);
  localparam logic [BCNT_W-1:0] BCNT_FULL = BCNT_W'(CTRL_W);
  localparam logic [BCNT_W-1:0] BCNT_OVER = BCNT_W'(CTRL_W + 1);

  logic sclkQ, trigQ, selQ;
  logic [CTRL_W-1:0] shiftReg;
  logic [BCNT_W-1:0] bitCnt;
  seqState_e state, nextState;

  wire sel = (slotSel == SEL_W'(SLOT_ADDR));
  wire sclkRise = sclk & ~sclkQ;
  wire trigHit = trig & ~trigQ & ctrlReg[B_CLKEN];
  wire clearAll = ~ctrlReg[B_RESETN];
  wire forceLoad = ~ctrlReg[B_LOADN];
  wire readOk = ctrlReg[B_READEN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      trigQ <= 1'b0;
      selQ <= 1'b0;
      shiftReg <= '0;
      bitCnt <= '0;
      ctrlReg <= CTRL_INIT;
      state <= ST_IDLE;
    end else begin
      sclkQ <= sclk;
      trigQ <= trig;
      selQ <= sel;
      if (!sel) begin
        bitCnt <= '0;
      end else if (sclkRise) begin
        shiftReg <= {shiftReg[CTRL_W-2:0], mosi};
        if (bitCnt != BCNT_OVER) bitCnt <= bitCnt + 1'b1;
      end
      if (selQ && !sel && bitCnt == BCNT_FULL) ctrlReg <= shiftReg;
      state <= nextState;
    end
  end

  always_comb begin
    stb = '0;
    nextState = state;
    stb.clearAll = clearAll;
    stb.rewind = ~clearAll & ~ctrlReg[B_REWINDN];
    if (clearAll) begin
      nextState = ST_IDLE;
    end else if (forceLoad) begin
      if (!listEmpty) begin
        stb.loadEntry = 1'b1;
        nextState = ST_RUN;
      end
    end else begin
      unique case (state)
        ST_RUN: begin
          if (trigHit) begin
            stb.decCnt = 1'b1;
            if (cntLast) nextState = ST_ADV;
          end
        end
        ST_ADV: begin
          if (readOk) begin
            if (atLast) begin
              if (ctrlReg[B_ONEPASS]) begin
                stb.blankCode = 1'b1;
                nextState = ST_DONE;
              end else begin
                stb.wrapPtr = 1'b1;
                nextState = ST_LOAD;
              end
            end else begin
              stb.stepPtr = 1'b1;
              nextState = ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (readOk) begin
            stb.loadEntry = 1'b1;
            nextState = ST_RUN;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 8,
  parameter int CODE_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                stb,
  input  logic                      wrEn,
  input  logic [CNT_W+CODE_W-1:0]   wrData,
  input  logic                      scanEn,
  output logic                      fifoFull,
  output logic                      fifoEmpty,
  output logic                      cntLast,
  output logic                      atLast,
  output logic [CNT_W-1:0]          sampleCnt,
  output logic [CODE_W-1:0]         scanCon
);

  localparam int ENTRY_W = CNT_W + CODE_W;
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] FILL_MAX = (PTR_W + 1)'(DEPTH);

  logic [ENTRY_W-1:0] listMem [DEPTH];
  logic [PTR_W:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CODE_W-1:0] curCode;
  logic [ENTRY_W-1:0] headEntry;

  assign fifoFull = (wrPtr == FILL_MAX);
  assign fifoEmpty = (wrPtr == '0);
  wire wrOk = wrEn & ~fifoFull & ~stb.clearAll;
  assign headEntry = listMem[rdPtr];
  assign atLast = !fifoEmpty && ({1'b0, rdPtr} == wrPtr - 1'b1);
  assign cntLast = (sampleCnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (wrOk) listMem[wrPtr[PTR_W-1:0]] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      sampleCnt <= '0;
      curCode <= '1;
    end else if (stb.clearAll) begin
      wrPtr <= '0;
      rdPtr <= '0;
      sampleCnt <= '0;
      curCode <= '1;
    end else begin
      if (wrOk) wrPtr <= wrPtr + 1'b1;
      if (stb.rewind || stb.wrapPtr) rdPtr <= '0;
      else if (stb.stepPtr) rdPtr <= rdPtr + 1'b1;
      if (stb.loadEntry) begin
        sampleCnt <= headEntry[ENTRY_W-1:CODE_W];
        curCode <= headEntry[CODE_W-1:0];
      end else begin
        if (stb.decCnt && sampleCnt != '0) sampleCnt <= sampleCnt - 1'b1;
        if (stb.blankCode) curCode <= '1;
      end
    end
  end

  assign scanCon = scanEn ? curCode : '1;

endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 8,
  parameter int CODE_W = 8,
  parameter int SEL_W = 4,
  parameter int SLOT_ADDR = 13
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclk,
  input  logic                    mosi,
  input  logic [SEL_W-1:0]        slotSel,
  input  logic                    trig,
  input  logic                    wrEn,
  input  logic [CNT_W+CODE_W-1:0] wrData,
  output logic                    fifoFull,
  output logic                    fifoEmpty,
  output logic [CODE_W-1:0]       scanCon,
  output logic [CNT_W-1:0]        sampleCnt,
  output logic                    done
);

  seqStrobe_t stb;
  logic [CTRL_W-1:0] ctrlReg;
  logic cntLast, atLast;

  scan_seq_ctrl #(.SEL_W(SEL_W), .SLOT_ADDR(SLOT_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .mosi(mosi), .slotSel(slotSel),
    .trig(trig), .listEmpty(fifoEmpty), .cntLast(cntLast), .atLast(atLast),
    .stb(stb), .ctrlReg(ctrlReg), .done(done)
  );

  scan_seq_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEn(wrEn), .wrData(wrData),
    .scanEn(ctrlReg[B_SCANEN]), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .cntLast(cntLast), .atLast(atLast), .sampleCnt(sampleCnt), .scanCon(scanCon)
  );

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int CNT_W = 8,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        ctrlReg,
  input logic              fifoFull,
  input logic              fifoEmpty,
  input logic [CODE_W-1:0] scanCon,
  input logic [CNT_W-1:0]  sampleCnt,
  input logic              done
);

  assert_lines_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[1] |-> scanCon == '1);

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && ctrlReg[3]) |=> fifoFull);

  assert_clear_all_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[3] |=> (fifoEmpty && sampleCnt == '0 && !done));

  assert_done_blank_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (scanCon == '1));

  assert_load_runs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[2] && ctrlReg[3] && !fifoEmpty) |=> !done);

endmodule

bind scan_seq scan_seq_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlReg(ctrlReg), .fifoFull(fifoFull),
  .fifoEmpty(fifoEmpty), .scanCon(scanCon), .sampleCnt(sampleCnt), .done(done)
);

// File: tb/tb_scan_seq.sv
module tb_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  typedef struct packed {
    logic [7:0] code;
    logic [7:0] cnt;
    logic done;
    logic empty;
    logic full;
  } snap_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, trig = 1'b0, wrEn = 1'b0;
  logic [3:0] slotSel = 4'd0;
  logic [15:0] wrData = '0;
  logic fifoFull, fifoEmpty, done;
  logic [7:0] scanCon, sampleCnt;

  int testsRun = 0;
  int testsFailed = 0;
  int pushed = 0;
  int popped = 0;
  bit finished = 1'b0;
  snap_t expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_seq dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .mosi(mosi), .slotSel(slotSel),
    .trig(trig), .wrEn(wrEn), .wrData(wrData), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .scanCon(scanCon), .sampleCnt(sampleCnt), .done(done)
  );

  // Monitor: pops expected snapshots and compares them against the outputs.
  always @(negedge clk) begin
    snap_t e;
    snap_t a;
    string r;
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      r = tagQ.pop_front();
      a = '{code: scanCon, cnt: sampleCnt, done: done, empty: fifoEmpty, full: fifoFull};
      testsRun++;
      if (a !== e) begin
        testsFailed++;
        $display("FAIL %s: actual code=%h cnt=%0d done=%b empty=%b full=%b expected code=%h cnt=%0d done=%b empty=%b full=%b",
                 r, a.code, a.cnt, a.done, a.empty, a.full, e.code, e.cnt, e.done, e.empty, e.full);
      end
      popped++;
    end
  end

  task automatic expectSnap(string req, logic [7:0] code, logic [7:0] cnt,
                            logic dn, logic emp, logic ful);
    snap_t e;
    e = '{code: code, cnt: cnt, done: dn, empty: emp, full: ful};
    expQ.push_back(e);
    tagQ.push_back(req);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(logic [15:0] w, int nBits, logic [3:0] slot);
    @(negedge clk);
    slotSel = slot;
    for (int i = 0; i < nBits; i++) begin
      mosi = w[15-i];
      sclk = 1'b1;
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
    end
    slotSel = 4'd0;
    settle(4);
  endtask

  task automatic writeCtrl(logic [7:0] b);
    sendBits({b, 8'h00}, 8, 4'd13);
  endtask

  task automatic pulseTrig(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      settle(4);
    end
  endtask

  task automatic pushEntry(logic [7:0] cnt, logic [7:0] code);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = {cnt, code};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    settle(3);
    rstN = 1'b1;
    settle(2);
    expectSnap("R13 reset state", 8'hFF, 8'd0, 1'b0, 1'b1, 1'b0);

    pushEntry(8'd2, 8'hA1);
    pushEntry(8'd1, 8'hB2);
    pushEntry(8'd3, 8'hC3);
    settle(2);
    expectSnap("R3 entries stored", 8'hFF, 8'd0, 1'b0, 1'b0, 1'b0);

    writeCtrl(8'h7B);
    expectSnap("R4 R2 load first entry", 8'hA1, 8'd2, 1'b0, 1'b0, 1'b0);
    writeCtrl(8'h7F);

    pulseTrig(1);
    expectSnap("R5 trigger decrements", 8'hA1, 8'd1, 1'b0, 1'b0, 1'b0);
    pulseTrig(1);
    expectSnap("R6 advance to 1-count entry", 8'hB2, 8'd1, 1'b0, 1'b0, 1'b0);
    pulseTrig(1);
    expectSnap("R6 advance to last entry", 8'hC3, 8'd3, 1'b0, 1'b0, 1'b0);
    pulseTrig(3);
    expectSnap("R8 one-pass stops", 8'hFF, 8'd0, 1'b1, 1'b0, 1'b0);
    pulseTrig(1);
    expectSnap("R8 trigger ignored when done", 8'hFF, 8'd0, 1'b1, 1'b0, 1'b0);

    writeCtrl(8'h2F);
    writeCtrl(8'h6B);
    expectSnap("R10 rewind keeps entries", 8'hA1, 8'd2, 1'b0, 1'b0, 1'b0);
    writeCtrl(8'h6F);
    pulseTrig(2);
    expectSnap("R9 second entry", 8'hB2, 8'd1, 1'b0, 1'b0, 1'b0);
    pulseTrig(1);
    pulseTrig(3);
    expectSnap("R9 wraps to first entry", 8'hA1, 8'd2, 1'b0, 1'b0, 1'b0);

    writeCtrl(8'h6E);
    pulseTrig(1);
    expectSnap("R5 trigger gated off", 8'hA1, 8'd2, 1'b0, 1'b0, 1'b0);
    writeCtrl(8'h6C);
    expectSnap("R12 lines disabled high", 8'hFF, 8'd2, 1'b0, 1'b0, 1'b0);

    writeCtrl(8'h4F);
    pulseTrig(2);
    settle(6);
    expectSnap("R7 read disabled holds", 8'hA1, 8'd0, 1'b0, 1'b0, 1'b0);
    writeCtrl(8'h6F);
    expectSnap("R7 read enabled advances", 8'hB2, 8'd1, 1'b0, 1'b0, 1'b0);

    sendBits({8'h6E, 8'h00}, 7, 4'd13);
    pulseTrig(1);
    expectSnap("R1 seven-bit burst ignored", 8'hC3, 8'd3, 1'b0, 1'b0, 1'b0);
    sendBits({8'h6E, 8'h00}, 9, 4'd13);
    pulseTrig(1);
    expectSnap("R1 nine-bit burst ignored", 8'hC3, 8'd2, 1'b0, 1'b0, 1'b0);
    sendBits({8'h6E, 8'h00}, 8, 4'd12);
    pulseTrig(1);
    expectSnap("R1 other slot ignored", 8'hC3, 8'd1, 1'b0, 1'b0, 1'b0);

    writeCtrl(8'h67);
    expectSnap("R11 reset bit clears", 8'hFF, 8'd0, 1'b0, 1'b1, 1'b0);
    writeCtrl(8'h6F);

    for (int i = 0; i < 31; i++) pushEntry(8'(i + 1), 8'(i));
    settle(2);
    expectSnap("R3 not full at 31", 8'hFF, 8'd0, 1'b0, 1'b0, 1'b0);
    pushEntry(8'd40, 8'h55);
    settle(2);
    expectSnap("R3 full at 32", 8'hFF, 8'd0, 1'b0, 1'b0, 1'b1);
    pushEntry(8'd50, 8'h66);
    writeCtrl(8'h2F);
    writeCtrl(8'h6B);
    expectSnap("R3 first entry kept after full", 8'h00, 8'd1, 1'b0, 1'b0, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule